// File: doc/BRIEF.md
# LCD Panel Power Sequencing Gate

This block sits between a display controller's timing generator and the pins of an LCD panel. It gates five control strobes (line pulse, pixel clock, frame pulse, AC bias and line enable), the 24-bit pixel data bus and a panel power-enable output. Two control bits decide what is gated. The enable bit releases the strobes. The power bit releases the pixel data and raises the power-enable output. Panel power can therefore reach the glass only after the control strobes are running. On power-down the data and power are removed before the strobes stop.

Software moves the block between three legal stages: dark, strobes live, and fully lit. It does this by issuing a write that carries both bit values and a flag that clears the error status. A write that skips a stage or reverses the order is refused, and a sticky sequence-error flag records the refusal. Any wait that the display needs between stages is timed by software. The block itself needs no minimum gap between two legal writes.

Every panel-side output leaves a flip-flop, so no combinational glitch can reach the pins. Raw inputs and stage changes both appear at the pins one clock edge after they are sampled.

Top module: `lcd_pwr_seq_gate`

## Requirements
- R1: While reset is applied and in the first cycle after it, all five strobe outputs, all 24 data outputs, the power-enable output and the three read-back bits are 0, whatever the raw inputs carry.
- R2: A write with enable=1 and power=0, accepted from the dark stage, sets the enable read-back at the write edge. From the next edge onward each strobe output equals its raw input delayed by one clock. The data outputs and the power-enable output stay 0.
- R3: A write with enable=1 and power=1, accepted from the strobes-live stage, sets the power read-back at the write edge. From the next edge, power-enable is 1 and the data outputs equal the raw data delayed by one clock.
- R4: The power-enable output is 1 only when the data outputs carry pixel data, and the power read-back is never 1 while the enable read-back is 0.
- R5: Power-down runs in reverse. Writing power=0 with enable=1 forces power-enable and data to 0 on the next edge while the strobes keep running. A later write with enable=0 returns the strobes to 0 on the edge after it.
- R6: A write that requests power=1 while the enable bit is clear, leaving enable at 0, is refused. Both bits keep their values and the sequence-error flag becomes 1.
- R7: A write that requests enable=0 while the power bit is set, leaving power at 1, is refused. The enable bit stays 1, the strobes keep running and the sequence-error flag becomes 1.
- R8: A write that changes both bits at once is refused. Neither bit nor any output stage changes, and the sequence-error flag becomes 1.
- R9: The sequence-error flag stays 1 until a write carries the clear flag as 1. When a write both carries the clear flag and is refused, the flag stays 1.
- R10: Two legal writes on consecutive cycles (enable, then power) are both accepted. The block needs no minimum gap between stages.
- R11: A write that repeats the current bit values is accepted, changes no output, and leaves the error flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tg_line_pulse | input | 1 | Raw line pulse from the timing generator |
| tg_pixel_clk | input | 1 | Raw pixel clock from the timing generator |
| tg_frame_pulse | input | 1 | Raw frame pulse from the timing generator |
| tg_ac_bias | input | 1 | Raw AC bias strobe |
| tg_line_enable | input | 1 | Raw line enable strobe |
| tg_pixel_data | input | DATA_W (24) | Raw pixel data |
| cfg_wr | input | 1 | Control write strobe, one cycle per write |
| cfg_enable | input | 1 | Requested enable bit value |
| cfg_power | input | 1 | Requested power bit value |
| cfg_err_clear | input | 1 | 1 clears the sequence-error flag (write-one-to-clear) |
| pnl_line_pulse | output | 1 | Gated line pulse |
| pnl_pixel_clk | output | 1 | Gated pixel clock |
| pnl_frame_pulse | output | 1 | Gated frame pulse |
| pnl_ac_bias | output | 1 | Gated AC bias |
| pnl_line_enable | output | 1 | Gated line enable |
| pnl_pixel_data | output | DATA_W (24) | Gated pixel data |
| pnl_power_en | output | 1 | Panel supply enable |
| rb_enable | output | 1 | Current enable bit |
| rb_power | output | 1 | Current power bit |
| rb_seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The stage logic is tried with every request value from each of the three legal stages. This tells the two accepted transitions out of each stage apart from the skipping, reversing and double-change writes. The data path is fed alternating, all-ones and single-bit patterns. These show that every lane is gated by the power bit and not by the enable bit, and that each lane is delayed by exactly one clock. The strobe path is fed complementary patterns across the stages. These separate a strobe that is really following its input from one that is stuck, and show the one-edge latency after each accepted write. The error flag is driven through refusals with and without the clear flag and through repeated-value writes. This shows that setting wins over clearing and that a harmless write leaves the flag alone.

// File: rtl/lcd_pwr_seq_pkg.sv
// Package: lcd_pwr_seq_pkg
// Shared types for the panel power sequencing gate: the pair of control
// bits and the verdict that a control write receives.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lcd_pwr_seq_pkg;

    localparam int NUM_STROBES = 5;

    // Strobe lane order inside the packed strobe vector.
    localparam int LANE_LINE  = 4;
    localparam int LANE_PIXCK = 3;
    localparam int LANE_FRAME = 2;
    localparam int LANE_ACB   = 1;
    localparam int LANE_LEN   = 0;

    typedef struct packed {
        logic enable;
        logic power;
    } ctl_bits_t;

    typedef enum logic [2:0] {
        WR_ACCEPT      = 3'd0,
        WR_SAME        = 3'd1,
        WR_BOTH_MOVE   = 3'd2,
        WR_PWR_NO_EN   = 3'd3,
        WR_EN_UNDER_PW = 3'd4
    } wr_verdict_e;

    // Classify a requested bit pair against the current pair.
    function automatic wr_verdict_e judge_write(input ctl_bits_t cur,
                                                input ctl_bits_t req);
        wr_verdict_e v;
        if (req == cur)
            v = WR_SAME;
        else if ((req.enable != cur.enable) && (req.power != cur.power))
            v = WR_BOTH_MOVE;
        else if (req.power && !req.enable)
            v = WR_PWR_NO_EN;
        else if (!req.enable && cur.power)
            v = WR_EN_UNDER_PW;
        else
            v = WR_ACCEPT;
        return v;
    endfunction

    function automatic logic is_refused(input wr_verdict_e v);
        return (v == WR_BOTH_MOVE) || (v == WR_PWR_NO_EN) ||
               (v == WR_EN_UNDER_PW);
    endfunction

endpackage

// File: rtl/lcd_seq_ctrl.sv
// Module: lcd_seq_ctrl
// Holds the enable and power bits and the sticky sequence-error flag.
// Judges each control write and applies only legal single-step moves.
// Assumes: wr is high for one cycle per write; synchronous active-low reset.
module lcd_seq_ctrl
    import lcd_pwr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  ctl_bits_t req,
    input  logic      err_clear,
    output ctl_bits_t cur,
    output logic      seq_err
);

    wr_verdict_e verdict;
    logic        take;

    // Classify the pending write against the current bits.
    always_comb begin
        verdict = judge_write(cur, req);
        take    = wr && (verdict == WR_ACCEPT);
    end

    // Control bit register: changes only on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (take)
            cur <= req;
    end

    // Sticky error flag: a refusal sets it, a write with clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_err <= 1'b0;
        else if (wr && is_refused(verdict))
            seq_err <= 1'b1;
        else if (wr && err_clear)
            seq_err <= 1'b0;
    end

endmodule

// File: rtl/lcd_strobe_gate.sv
// Module: lcd_strobe_gate
// Registers each control strobe lane, forced low while release is clear.
// Assumes: raw strobes are synchronous to clk; synchronous active-low reset.
module lcd_strobe_gate #(
    parameter int LANES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_en,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] pin
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One output flop per strobe lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin[g] <= 1'b0;
            else
                pin[g] <= raw[g] & release_en;
        end
    end

endmodule

// File: rtl/lcd_data_power_gate.sv
// Module: lcd_data_power_gate
// Registers the pixel data lanes and the panel power enable in one stage,
// so power is high exactly in the cycles where data is being passed.
// Assumes: raw data is synchronous to clk; synchronous active-low reset.
module lcd_data_power_gate #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_bit,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] pin,
    output logic             power_en
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        // One output flop per data lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pin[g] <= 1'b0;
            else
                pin[g] <= raw[g] & power_bit;
        end
    end

    // Panel power flop, aligned with the data lanes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            power_en <= 1'b0;
        else
            power_en <= power_bit;
    end

endmodule

// File: rtl/lcd_pwr_seq_gate.sv
// Module: lcd_pwr_seq_gate (top)
// Staged gate between a timing generator and an LCD panel. The enable bit
// releases the control strobes. The power bit releases the pixel data and
// raises panel power. Out-of-order writes are refused and flagged.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module lcd_pwr_seq_gate
    import lcd_pwr_seq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tg_line_pulse,
    input  logic              tg_pixel_clk,
    input  logic              tg_frame_pulse,
    input  logic              tg_ac_bias,
    input  logic              tg_line_enable,
    input  logic [DATA_W-1:0] tg_pixel_data,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic              cfg_power,
    input  logic              cfg_err_clear,
    output logic              pnl_line_pulse,
    output logic              pnl_pixel_clk,
    output logic              pnl_frame_pulse,
    output logic              pnl_ac_bias,
    output logic              pnl_line_enable,
    output logic [DATA_W-1:0] pnl_pixel_data,
    output logic              pnl_power_en,
    output logic              rb_enable,
    output logic              rb_power,
    output logic              rb_seq_err
);

    ctl_bits_t              req_bits;
    ctl_bits_t              cur_bits;
    logic [NUM_STROBES-1:0] raw_strobes;
    logic [NUM_STROBES-1:0] pin_strobes;

    // Pack the request and the raw strobes into lane order.
    always_comb begin
        req_bits.enable          = cfg_enable;
        req_bits.power           = cfg_power;
        raw_strobes[LANE_LINE]   = tg_line_pulse;
        raw_strobes[LANE_PIXCK]  = tg_pixel_clk;
        raw_strobes[LANE_FRAME]  = tg_frame_pulse;
        raw_strobes[LANE_ACB]    = tg_ac_bias;
        raw_strobes[LANE_LEN]    = tg_line_enable;
    end

    lcd_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .req       (req_bits),
        .err_clear (cfg_err_clear),
        .cur       (cur_bits),
        .seq_err   (rb_seq_err)
    );

    lcd_strobe_gate #(.LANES(NUM_STROBES)) u_strobes (
        .clk        (clk),
        .rst_n      (rst_n),
        .release_en (cur_bits.enable),
        .raw        (raw_strobes),
        .pin        (pin_strobes)
    );

    lcd_data_power_gate #(.WIDTH(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .power_bit (cur_bits.power),
        .raw       (tg_pixel_data),
        .pin       (pnl_pixel_data),
        .power_en  (pnl_power_en)
    );

    // Unpack gated strobes and expose the read-back bits.
    always_comb begin
        pnl_line_pulse  = pin_strobes[LANE_LINE];
        pnl_pixel_clk   = pin_strobes[LANE_PIXCK];
        pnl_frame_pulse = pin_strobes[LANE_FRAME];
        pnl_ac_bias     = pin_strobes[LANE_ACB];
        pnl_line_enable = pin_strobes[LANE_LEN];
        rb_enable       = cur_bits.enable;
        rb_power        = cur_bits.power;
    end

endmodule

// File: rtl/lcd_pwr_seq_gate_chk.sv
// Module: lcd_pwr_seq_gate_chk
// Assertion checker for the sequencing gate, attached by bind below.
// Assumes: synchronous active-low reset; checks run only out of reset.
module lcd_pwr_seq_gate_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_enable,
    input logic              cfg_power,
    input logic [DATA_W-1:0] tg_pixel_data,
    input logic              pnl_line_pulse,
    input logic              pnl_pixel_clk,
    input logic              pnl_frame_pulse,
    input logic              pnl_ac_bias,
    input logic              pnl_line_enable,
    input logic [DATA_W-1:0] pnl_pixel_data,
    input logic              pnl_power_en,
    input logic              rb_enable,
    input logic              rb_power,
    input logic              rb_seq_err
);

    logic [4:0] strobes;
    assign strobes = {pnl_line_pulse, pnl_pixel_clk, pnl_frame_pulse,
                      pnl_ac_bias, pnl_line_enable};

    assert_power_implies_enable_R4: assert property (@(posedge clk)
        disable iff (!rst_n) rb_power |-> rb_enable);

    assert_dark_data_when_unpowered_R4: assert property (@(posedge clk)
        disable iff (!rst_n) !pnl_power_en |-> (pnl_pixel_data == '0));

    assert_power_pin_follows_bit_R3: assert property (@(posedge clk)
        disable iff (!rst_n) rb_power |=> pnl_power_en);

    assert_power_pin_drops_R5: assert property (@(posedge clk)
        disable iff (!rst_n) !rb_power |=> !pnl_power_en);

    assert_data_follows_raw_R3: assert property (@(posedge clk)
        disable iff (!rst_n) rb_power |=> (pnl_pixel_data == $past(tg_pixel_data)));

    assert_strobes_low_when_disabled_R2: assert property (@(posedge clk)
        disable iff (!rst_n) !rb_enable |=> (strobes == 5'b0));

    assert_power_first_refused_R6: assert property (@(posedge clk)
        disable iff (!rst_n) (cfg_wr && !rb_enable && !cfg_enable && cfg_power)
        |=> (!rb_power && rb_seq_err));

    assert_enable_clear_refused_R7: assert property (@(posedge clk)
        disable iff (!rst_n) (cfg_wr && rb_power && !cfg_enable && cfg_power)
        |=> (rb_enable && rb_seq_err));

    assert_double_move_refused_R8: assert property (@(posedge clk)
        disable iff (!rst_n)
        (cfg_wr && (cfg_enable != rb_enable) && (cfg_power != rb_power))
        |=> ($stable(rb_enable) && $stable(rb_power) && rb_seq_err));

    assert_err_sticky_R9: assert property (@(posedge clk)
        disable iff (!rst_n) (rb_seq_err && !cfg_wr) |=> rb_seq_err);

endmodule

bind lcd_pwr_seq_gate lcd_pwr_seq_gate_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr          (cfg_wr),
    .cfg_enable      (cfg_enable),
    .cfg_power       (cfg_power),
    .tg_pixel_data   (tg_pixel_data),
    .pnl_line_pulse  (pnl_line_pulse),
    .pnl_pixel_clk   (pnl_pixel_clk),
    .pnl_frame_pulse (pnl_frame_pulse),
    .pnl_ac_bias     (pnl_ac_bias),
    .pnl_line_enable (pnl_line_enable),
    .pnl_pixel_data  (pnl_pixel_data),
    .pnl_power_en    (pnl_power_en),
    .rb_enable       (rb_enable),
    .rb_power        (rb_power),
    .rb_seq_err      (rb_seq_err)
);

// File: tb/lcd_pwr_seq_gate_test.sv
`timescale 1ns/1ps
// Directed bench for the panel power sequencing gate.
module lcd_pwr_seq_gate_test;

    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    raw_s = 5'b0;
    logic [DW-1:0] raw_d = '0;
    logic          cfg_wr = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          cfg_power = 1'b0;
    logic          cfg_err_clear = 1'b0;
    logic          p_line, p_pix, p_frame, p_acb, p_len;
    logic [DW-1:0] p_data;
    logic          p_pwr, rb_en, rb_pw, rb_err;
    logic [4:0]    pin_s;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    assign pin_s = {p_line, p_pix, p_frame, p_acb, p_len};

    lcd_pwr_seq_gate #(.DATA_W(DW)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tg_line_pulse   (raw_s[4]),
        .tg_pixel_clk    (raw_s[3]),
        .tg_frame_pulse  (raw_s[2]),
        .tg_ac_bias      (raw_s[1]),
        .tg_line_enable  (raw_s[0]),
        .tg_pixel_data   (raw_d),
        .cfg_wr          (cfg_wr),
        .cfg_enable      (cfg_enable),
        .cfg_power       (cfg_power),
        .cfg_err_clear   (cfg_err_clear),
        .pnl_line_pulse  (p_line),
        .pnl_pixel_clk   (p_pix),
        .pnl_frame_pulse (p_frame),
        .pnl_ac_bias     (p_acb),
        .pnl_line_enable (p_len),
        .pnl_pixel_data  (p_data),
        .pnl_power_en    (p_pwr),
        .rb_enable       (rb_en),
        .rb_power        (rb_pw),
        .rb_seq_err      (rb_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One write cycle; returns at the next negedge (write edge has passed).
    task automatic cfg_write(input logic en, input logic pw, input logic clr);
        cfg_enable    = en;
        cfg_power     = pw;
        cfg_err_clear = clr;
        cfg_wr        = 1'b1;
        @(negedge clk);
        cfg_wr        = 1'b0;
        cfg_err_clear = 1'b0;
    endtask

    task automatic t_reset();
        raw_s = 5'b11111;
        raw_d = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        check("R1", "strobes in reset", {27'b0, pin_s}, 32'h0);
        check("R1", "data in reset", {8'b0, p_data}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "strobes after reset", {27'b0, pin_s}, 32'h0);
        check("R1", "power after reset", {31'b0, p_pwr}, 32'h0);
        check("R1", "readback after reset", {29'b0, rb_en, rb_pw, rb_err}, 32'h0);
    endtask

    task automatic t_enable_stage();
        raw_s = 5'b10101;
        raw_d = 24'h123456;
        cfg_write(1'b1, 1'b0, 1'b0);
        check("R2", "enable readback", {31'b0, rb_en}, 32'h1);
        check("R2", "strobes still low at write edge", {27'b0, pin_s}, 32'h0);
        @(negedge clk);
        check("R2", "strobes released", {27'b0, pin_s}, 32'h15);
        check("R2", "data held low", {8'b0, p_data}, 32'h0);
        check("R2", "power held low", {31'b0, p_pwr}, 32'h0);
        raw_s = 5'b01010;
        @(negedge clk);
        check("R2", "strobes follow raw", {27'b0, pin_s}, 32'h0A);
    endtask

    task automatic t_power_stage();
        raw_d = 24'hA5A5A5;
        cfg_write(1'b1, 1'b1, 1'b0);
        check("R3", "power readback", {31'b0, rb_pw}, 32'h1);
        check("R3", "power pin one edge later", {31'b0, p_pwr}, 32'h0);
        @(negedge clk);
        check("R3", "power pin high", {31'b0, p_pwr}, 32'h1);
        check("R3", "data A5A5A5", {8'b0, p_data}, 32'hA5A5A5);
        raw_d = 24'h5A5A5A; @(negedge clk);
        check("R3", "data 5A5A5A", {8'b0, p_data}, 32'h5A5A5A);
        raw_d = 24'hFFFFFF; @(negedge clk);
        check("R3", "data all ones", {8'b0, p_data}, 32'hFFFFFF);
        raw_d = 24'h000001; @(negedge clk);
        check("R4", "single lane with power", {8'b0, p_data}, 32'h000001);
        check("R3", "no error", {31'b0, rb_err}, 32'h0);
    endtask

    task automatic t_power_down();
        raw_s = 5'b11011;
        raw_d = 24'h0F0F0F;
        cfg_write(1'b1, 1'b0, 1'b0);
        check("R5", "power readback cleared", {31'b0, rb_pw}, 32'h0);
        @(negedge clk);
        check("R5", "power pin low", {31'b0, p_pwr}, 32'h0);
        check("R5", "data forced low", {8'b0, p_data}, 32'h0);
        check("R5", "strobes still live", {27'b0, pin_s}, 32'h1B);
        cfg_write(1'b0, 1'b0, 1'b0);
        check("R5", "enable readback cleared", {31'b0, rb_en}, 32'h0);
        @(negedge clk);
        check("R5", "strobes low", {27'b0, pin_s}, 32'h0);
    endtask

    task automatic t_power_first();
        raw_d = 24'hFFFFFF;
        cfg_write(1'b0, 1'b1, 1'b0);
        check("R6", "power stays clear", {31'b0, rb_pw}, 32'h0);
        check("R6", "error set", {31'b0, rb_err}, 32'h1);
        @(negedge clk);
        check("R6", "power pin low", {31'b0, p_pwr}, 32'h0);
        check("R6", "data low", {8'b0, p_data}, 32'h0);
        cfg_write(1'b0, 1'b0, 1'b1);
        check("R9", "clear by write-one", {31'b0, rb_err}, 32'h0);
    endtask

    task automatic t_both_move();
        raw_s = 5'b11111;
        cfg_write(1'b1, 1'b1, 1'b0);
        check("R8", "bits unchanged from dark", {30'b0, rb_en, rb_pw}, 32'h0);
        check("R8", "error set", {31'b0, rb_err}, 32'h1);
        @(negedge clk);
        check("R8", "strobes stay low", {27'b0, pin_s}, 32'h0);
        cfg_write(1'b0, 1'b0, 1'b1);
        cfg_write(1'b1, 1'b0, 1'b0);
        cfg_write(1'b1, 1'b1, 1'b0);
        cfg_write(1'b0, 1'b0, 1'b0);
        check("R8", "bits unchanged from lit", {30'b0, rb_en, rb_pw}, 32'h3);
        check("R8", "error set from lit", {31'b0, rb_err}, 32'h1);
        @(negedge clk);
        check("R8", "power pin stays", {31'b0, p_pwr}, 32'h1);
        cfg_write(1'b1, 1'b1, 1'b1);
        check("R9", "clear on same-value write", {31'b0, rb_err}, 32'h0);
    endtask

    task automatic t_enable_under_power();
        raw_s = 5'b00110;
        cfg_write(1'b0, 1'b1, 1'b0);
        check("R7", "enable stays", {30'b0, rb_en, rb_pw}, 32'h3);
        check("R7", "error set", {31'b0, rb_err}, 32'h1);
        @(negedge clk);
        check("R7", "strobes still live", {27'b0, pin_s}, 32'h06);
    endtask

    task automatic t_err_sticky();
        repeat (4) @(negedge clk);
        check("R9", "flag holds while idle", {31'b0, rb_err}, 32'h1);
        cfg_write(1'b1, 1'b1, 1'b0);
        check("R11", "same write keeps bits", {30'b0, rb_en, rb_pw}, 32'h3);
        check("R11", "same write keeps flag", {31'b0, rb_err}, 32'h1);
        cfg_write(1'b0, 1'b1, 1'b1);
        check("R9", "refusal beats clear", {31'b0, rb_err}, 32'h1);
        cfg_write(1'b1, 1'b1, 1'b1);
        check("R9", "cleared", {31'b0, rb_err}, 32'h0);
        cfg_write(1'b1, 1'b0, 1'b0);
        cfg_write(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back();
        raw_s = 5'b10011;
        raw_d = 24'h3C3C3C;
        cfg_write(1'b1, 1'b0, 1'b0);
        cfg_write(1'b1, 1'b1, 1'b0);
        check("R10", "both accepted", {29'b0, rb_en, rb_pw, rb_err}, 32'h6);
        check("R10", "strobes live", {27'b0, pin_s}, 32'h13);
        check("R10", "power not yet", {31'b0, p_pwr}, 32'h0);
        @(negedge clk);
        check("R10", "power pin high", {31'b0, p_pwr}, 32'h1);
        check("R10", "data live", {8'b0, p_data}, 32'h3C3C3C);
        cfg_write(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        cfg_write(1'b1, 1'b0, 1'b0);
        check("R11", "same write, no error", {29'b0, rb_en, rb_pw, rb_err}, 32'h4);
        @(negedge clk);
        check("R11", "strobes unchanged", {27'b0, pin_s}, 32'h13);
        check("R11", "power stays low", {31'b0, p_pwr}, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable_stage();
        t_power_stage();
        t_power_down();
        t_power_first();
        t_both_move();
        t_enable_under_power();
        t_err_sticky();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule